// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Gated Shared Interrupt

This block is a sixteen-pin general-purpose I/O port attached to a small memory-mapped register bus. Software sets each pin's direction and drives output levels through a masked write. In that write the upper half of the data word selects which low-half value bits are applied, so one pin can change without a read-modify-write. Input levels pass through a two-flop synchronizer and can be read back as a single word.

The eight upper pins feed one shared, active-high interrupt. Each synchronized pin level is ANDed with its own enable bit, the products are ORed, and the result is registered. A two-bit control word stops the block's clock and holds its registers in soft reset. Bring-up writes 3 and then 1. Writing 2 parks the block in its low-power state, which is also the state after hardware reset.

The bus has no back-pressure: a request is accepted on every cycle that `bus_valid` is high. A read returns its data with `bus_rvalid` on the following cycle.

Top module: `gpio_shared_irq`

## Requirements
- R1: After hardware reset the control word reads 2 (bit 1 soft reset set, bit 0 clock enable clear), and `pin_oe`, `pin_out` and `irq_shared` are all 0.
- R2: Offset 0x00 holds the direction word. A 1 in bit n drives `pin_oe[n]` high from the edge that accepts the write, and the word reads back unchanged.
- R3: A write to offset 0x08 sets output bit n to data bit n only where data bit n+16 is 1. Every other output bit keeps its value, and `pin_out` shows the result from the accepting edge.
- R4: A read of offset 0x08 returns the output latch in bits 15:0 and zeros in bits 31:16.
- R5: A read of offset 0x0C returns the levels of `pin_in` after a two-flop synchronizer.
- R6: Offset 0x10 holds the interrupt-enable word and reads back what was written.
- R7: `irq_shared` is the registered OR of `pin_in[15:8]` ANDed with enable bits 15:8. After a pin change it rises on the third clock edge, and pins 7:0 never affect it.
- R8: Offset 0x14 is the control word: bit 0 enables the clock, bit 1 holds soft reset. It reads back in bits 1:0.
- R9: While soft reset is set, the direction, output and enable words are held at zero and bus writes to them are ignored.
- R10: While the clock-enable bit is 0, the synchronized pin state and `irq_shared` are forced to 0 from the next edge.
- R11: A read request returns data with `bus_rvalid` one cycle later. Offsets that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe, accepted every cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Output latch to pads |
| pin_oe | output | 16 | Per-pin output enable (direction) |
| irq_shared | output | 1 | Shared interrupt from pins 15:8 |

## Verification
Register writes take effect on the edge that accepts them. `pin_oe` and `pin_out` are therefore compared at the falling edge right after the write strobe. A read result is due one edge after its request, so the driver pushes the expected word into a queue and the monitor pops it on the falling edge where `bus_rvalid` is high. A pin change needs two edges to reach the synchronized state and a third to reach `irq_shared`, so the interrupt is checked low after the second edge and high after the third. Clearing the enable bit or the clock enable leaves `irq_shared` unchanged for one edge and drops it on the next; the checks wait for that edge before sampling.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFS_W = 5;
  localparam logic [OFS_W-1:0] OFS_DIR  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_OUT  = 5'h08;
  localparam logic [OFS_W-1:0] OFS_PINS = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_IEN  = 5'h10;
  localparam logic [OFS_W-1:0] OFS_CTRL = 5'h14;
  localparam int unsigned CTRL_CLK_BIT = 0;
  localparam int unsigned CTRL_RST_BIT = 1;
  localparam logic [1:0] CTRL_POR = 2'b10;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned DATA_W = 2 * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  out_o,
  output logic [NPINS-1:0]  ien_o,
  output logic              clk_en_o,
  output logic              soft_rst_o
);
  logic [NPINS-1:0] dir_q, out_q, ien_q;
  logic [1:0]       ctrl_q;
  logic [NPINS-1:0] wmask, wval;

  assign wval  = wdata[NPINS-1:0];
  assign wmask = wdata[DATA_W-1:NPINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_POR;
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_en && addr == OFS_CTRL) ctrl_q <= wdata[1:0];
      if (ctrl_q[CTRL_RST_BIT]) begin
        dir_q <= '0;
        out_q <= '0;
        ien_q <= '0;
      end else if (wr_en) begin
        if (addr == OFS_DIR) dir_q <= wval;
        if (addr == OFS_OUT) out_q <= (out_q & ~wmask) | (wval & wmask);
        if (addr == OFS_IEN) ien_q <= wval;
      end
    end
  end

  assign dir_o      = dir_q;
  assign out_o      = out_q;
  assign ien_o      = ien_q;
  assign clk_en_o   = ctrl_q[CTRL_CLK_BIT];
  assign soft_rst_o = ctrl_q[CTRL_RST_BIT];

  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (dir_q == '0 && out_q == '0 && ien_q == '0)); // R9

  AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_OUT) |=>
      (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0)); // R3
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else if (!en) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

  AST_SYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (q == '0)); // R10
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] level,
  input  logic [N-1:0] ien,
  output logic         irq
);
  logic [N-1:0] hits;
  logic         irq_q;

  assign hits = level & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (!en) irq_q <= 1'b0;
    else          irq_q <= |hits;
  end

  assign irq = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq); // R10

  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |=> !irq); // R7
endmodule

// File: rtl/gpio_shared_irq.sv
module gpio_shared_irq
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned IRQ_LO = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [15:0]       pin_in,
  output logic [15:0]       pin_out,
  output logic [15:0]       pin_oe,
  output logic              irq_shared
);
  localparam int unsigned DATA_W = 2 * NPINS;
  localparam int unsigned IRQ_N  = NPINS - IRQ_LO;

  logic [NPINS-1:0] dir_w, out_w, ien_w, state_w;
  logic             clk_en_w, soft_rst_w;
  logic [DATA_W-1:0] rd_next, rdata_q;
  logic             rvalid_q;

  gpio_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_valid && bus_write), .addr(bus_addr), .wdata(bus_wdata),
    .dir_o(dir_w), .out_o(out_w), .ien_o(ien_w),
    .clk_en_o(clk_en_w), .soft_rst_o(soft_rst_w)
  );

  gpio_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(clk_en_w), .d(pin_in), .q(state_w)
  );

  gpio_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .en(clk_en_w),
    .level(state_w[NPINS-1:IRQ_LO]), .ien(ien_w[NPINS-1:IRQ_LO]),
    .irq(irq_shared)
  );

  always_comb begin
    rd_next = '0;
    unique case (bus_addr)
      OFS_DIR:  rd_next[NPINS-1:0] = dir_w;
      OFS_OUT:  rd_next[NPINS-1:0] = out_w;
      OFS_PINS: rd_next[NPINS-1:0] = state_w;
      OFS_IEN:  rd_next[NPINS-1:0] = ien_w;
      OFS_CTRL: rd_next[1:0] = {soft_rst_w, clk_en_w};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) rdata_q <= rd_next;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign pin_out    = out_w;
  assign pin_oe     = dir_w;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid); // R11

  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid); // R11

  AST_OUT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFS_OUT) |=>
      (bus_rdata[DATA_W-1:NPINS] == '0)); // R4
endmodule

// File: tb/gpio_shared_irq_test.sv
module gpio_shared_irq_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq_shared;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_shared_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_shared(irq_shared)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R11 unexpected rvalid actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    check("R1 pin_out", {16'h0, pin_out}, 32'h0);
    check("R1 irq", {31'h0, irq_shared}, 32'h0);
    rd(5'h14, 32'h2, "R1 ctrl after reset");

    // R9: writes ignored while soft reset is set
    wr(5'h00, 32'h0000_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    check("R9 pin_oe held", {16'h0, pin_oe}, 32'h0);
    check("R9 pin_out held", {16'h0, pin_out}, 32'h0);
    rd(5'h00, 32'h0, "R9 dir held");

    // R8 bring-up
    wr(5'h14, 32'h3);
    rd(5'h14, 32'h3, "R8 ctrl=3");
    wr(5'h14, 32'h1);
    rd(5'h14, 32'h1, "R8 ctrl=1");

    // R2 direction
    wr(5'h00, 32'h0000_00F0);
    check("R2 pin_oe", {16'h0, pin_oe}, 32'h0000_00F0);
    rd(5'h00, 32'h0000_00F0, "R2 dir readback");

    // R3 masked output writes
    wr(5'h08, 32'hFFFF_1234);
    check("R3 full mask", {16'h0, pin_out}, 32'h0000_1234);
    wr(5'h08, 32'h00FF_0000);
    check("R3 low byte cleared", {16'h0, pin_out}, 32'h0000_1200);
    wr(5'h08, 32'h0000_FFFF);
    check("R3 zero mask keeps", {16'h0, pin_out}, 32'h0000_1200);
    wr(5'h08, 32'h8001_8001);
    check("R3 single bits", {16'h0, pin_out}, 32'h0000_9201);
    rd(5'h08, 32'h0000_9201, "R4 out readback");

    // R5 pin state
    @(negedge clk); pin_in = 16'hA55A;
    idle(3);
    rd(5'h0C, 32'h0000_A55A, "R5 pin state");

    // R6 / R7
    @(negedge clk); pin_in = 16'h0000;
    idle(3);
    wr(5'h10, 32'h0000_FFFF);
    rd(5'h10, 32'h0000_FFFF, "R6 ien readback");
    @(negedge clk); pin_in = 16'h00FF;
    idle(4);
    check("R7 low pins ignored", {31'h0, irq_shared}, 32'h0);
    @(negedge clk); pin_in = 16'h80FF;
    idle(2);
    check("R7 not yet after two edges", {31'h0, irq_shared}, 32'h0);
    idle(1);
    check("R7 raised on third edge", {31'h0, irq_shared}, 32'h1);
    wr(5'h10, 32'h0000_7FFF);
    idle(1);
    check("R7 enable bit gates", {31'h0, irq_shared}, 32'h0);
    wr(5'h10, 32'h0000_8000);
    idle(1);
    check("R7 re-enabled", {31'h0, irq_shared}, 32'h1);

    // R10 clock gated
    wr(5'h14, 32'h0);
    idle(1);
    check("R10 irq frozen", {31'h0, irq_shared}, 32'h0);
    rd(5'h0C, 32'h0, "R10 pin state frozen");
    rd(5'h00, 32'h0000_00F0, "R8 dir kept without reset");

    // R9 low-power state clears registers
    wr(5'h14, 32'h2);
    idle(1);
    check("R9 pin_oe cleared", {16'h0, pin_oe}, 32'h0);
    check("R9 pin_out cleared", {16'h0, pin_out}, 32'h0);
    rd(5'h10, 32'h0, "R9 ien cleared");
    rd(5'h14, 32'h2, "R8 ctrl=2");

    // R11 unmapped offset
    rd(5'h04, 32'h0, "R11 unmapped");
    rd(5'h1C, 32'h0, "R11 unmapped high");
    idle(3);
    check("R11 all reads returned", exp_q.size(), 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule